// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

A memory-mapped real-time clock peripheral. It keeps a 32-bit seconds count that advances by one on each cycle where the one-pulse-per-second enable input is high. Software can load a new count, program a match value, and mask, inspect and clear a single alarm interrupt. Both the count and the comparison wrap modulo 2^32.

The register window is 4 KB and word aligned. It is reached through a simple synchronous bus. A write takes effect on the rising clock edge. Read data is a combinational function of the address and the current register state. The interrupt output is a level signal: it is the raw alarm bit gated by the mask bit. The top eight words of the window hold fixed identification bytes.

The alarm fires only on exact equality between the count and the match value. It fires on a tick that reaches the match. It also fires at once when a load or match write leaves the two equal.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset, the count, match, load, mask and raw alarm registers all read 0, and `alarm_irq` is low.
- R2: Each cycle with `pps_tick` high and no load write adds 1 to the count, which wraps from 0xFFFFFFFF to 0. Offset 0x00 reads the count. Writes to offset 0x00 have no effect.
- R3: A write to offset 0x08 sets the count to the written data from the next cycle, and offset 0x08 reads that data back. When a tick and a load write fall in the same cycle, the load value is taken.
- R4: Offset 0x04 holds the match value. Raw alarm bit 0 at offset 0x14 becomes 1 in the cycle after a tick that makes the count equal to the match. A match value below the count fires after the count wraps.
- R5: A write to offset 0x04 or 0x08 that leaves the count equal to the match value sets the raw alarm bit in the next cycle, with no tick needed.
- R6: A write to offset 0x10 keeps only data bit 0 as the mask. Offset 0x18 reads raw AND mask in bit 0, and `alarm_irq` equals that bit.
- R7: A write to offset 0x1C with data bit 0 set clears the raw alarm bit; with bit 0 clear it has no effect. A set event in the same cycle wins, and the bit stays 1. Offset 0x1C reads 0.
- R8: Offset 0x0C always reads 1 and ignores writes. Writes to offsets 0x14 and 0x18 have no effect. Unmapped or misaligned offsets (for example 0x020, 0x003, 0xFDC) read 0.
- R9: Offset 0xFE0 + 4*i, for i = 0 to 7, reads one byte in bits 7:0, in the order 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_tick | input | 1 | One-cycle count enable, once per second |
| bus_addr | input | 12 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| alarm_irq | output | 1 | Level interrupt: raw alarm AND mask |

## Verification
A tick or a write changes the registers at the rising edge on which it is sampled. From then on the count, match, load, mask and raw readback all show the new values, and so does `alarm_irq`, because both the read data and the interrupt are combinational from the registers. The bench drives each stimulus at a falling edge. It updates its own model right after the following rising edge. It then compares read data and the interrupt at the next falling edge plus a short delay, with tick and write held low, so no state changes while it samples. Same-cycle collisions are driven in a single cycle, and the result is read one cycle later: a load against a tick, and a clear against a set event.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  // Fixed 4 KB register window
  localparam int unsigned WIN_AW = 12;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_MATCH,
    SEL_LOAD,
    SEL_CTRL,
    SEL_MASK,
    SEL_RAW,
    SEL_MSTAT,
    SEL_CLEAR,
    SEL_ID
  } sel_e;

  typedef struct packed {
    logic load;
    logic match;
    logic mask;
    logic clear;
  } wr_stb_t;

  // Word-aligned decode of a byte offset
  function automatic sel_e decode_sel(input logic [WIN_AW-1:0] a);
    sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[WIN_AW-1:5] == '1) begin
        s = SEL_ID;
      end else begin
        case (a[WIN_AW-1:2])
          10'h000: s = SEL_COUNT;
          10'h001: s = SEL_MATCH;
          10'h002: s = SEL_LOAD;
          10'h003: s = SEL_CTRL;
          10'h004: s = SEL_MASK;
          10'h005: s = SEL_RAW;
          10'h006: s = SEL_MSTAT;
          10'h007: s = SEL_CLEAR;
          default: s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

  // Identification byte for word index 0..7 of the top block
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sec_rtc_decode.sv
module sec_rtc_decode
  import sec_rtc_pkg::*;
(
  input  logic [WIN_AW-1:0] addr,
  input  logic              we,
  output sel_e              sel,
  output wr_stb_t           stb
);

  assign sel = decode_sel(addr);

  // Only writable locations produce a strobe; everything else is dropped
  always_comb begin
    stb       = '0;
    stb.load  = we && (sel == SEL_LOAD);
    stb.match = we && (sel == SEL_MATCH);
    stb.mask  = we && (sel == SEL_MASK);
    stb.clear = we && (sel == SEL_CLEAR);
  end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] load_q
);

  // Next count: a load beats a tick, and a tick wraps modulo 2^CNT_W
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic             t,
    input logic             ld,
    input logic [CNT_W-1:0] val
  );
    logic [CNT_W-1:0] n;
    if (ld)     n = val;
    else if (t) n = cur + CNT_W'(1);
    else        n = cur;
    return n;
  endfunction

  assign cnt_nxt = step_count(cnt_q, tick, ld_we, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (ld_we) load_q <= wdata;
    end
  end

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_we) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> (cnt_q == $past(wdata) && load_q == $past(wdata)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_we) |=> $stable(cnt_q));

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_we,
  input  logic             mt_we,
  input  logic             mk_we,
  input  logic             clr_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] match_q,
  output logic             mask_q,
  output logic             raw_q,
  output logic             set_evt,
  output logic             irq
);

  logic [CNT_W-1:0] match_nxt;
  logic             clr_hit;

  assign match_nxt = mt_we ? wdata : match_q;

  // A set event needs something to have changed the count or the match;
  // the compare uses the post-update values
  assign set_evt = (tick || ld_we || mt_we) && (cnt_nxt == match_nxt);
  assign clr_hit = clr_we && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      match_q <= match_nxt;
      if (mk_we) mask_q <= wdata[0];
      if (set_evt)      raw_q <= 1'b1;
      else if (clr_hit) raw_q <= 1'b0;
    end
  end

  assign irq = raw_q & mask_q;

  // R4
  set_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> raw_q);

  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_evt) |=> !raw_q);

  // R7
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_hit) |=> raw_q);

  // R6
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mk_we |=> (mask_q == $past(wdata[0])));

endmodule

// File: rtl/sec_rtc_rdmux.sv
module sec_rtc_rdmux
  import sec_rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  sel_e             sel,
  input  logic [2:0]       id_idx,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] match_q,
  input  logic [CNT_W-1:0] load_q,
  input  logic             mask_q,
  input  logic             raw_q,
  output logic [CNT_W-1:0] rdata
);

  localparam int unsigned PAD_W = CNT_W - 8;

  always_comb begin
    case (sel)
      SEL_COUNT: rdata = cnt_q;
      SEL_MATCH: rdata = match_q;
      SEL_LOAD:  rdata = load_q;
      SEL_CTRL:  rdata = CNT_W'(1);
      SEL_MASK:  rdata = CNT_W'(mask_q);
      SEL_RAW:   rdata = CNT_W'(raw_q);
      SEL_MSTAT: rdata = CNT_W'(raw_q & mask_q);
      SEL_ID:    rdata = {{PAD_W{1'b0}}, id_byte(id_idx)};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pps_tick,
  input  logic [WIN_AW-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [CNT_W-1:0]       bus_wdata,
  output logic [CNT_W-1:0]       bus_rdata,
  output logic                   alarm_irq
);

  sel_e             sel;
  wr_stb_t          stb;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, load_q, match_q;
  logic             mask_q, raw_q, set_evt;

  sec_rtc_decode u_decode (
    .addr (bus_addr),
    .we   (bus_we),
    .sel  (sel),
    .stb  (stb)
  );

  sec_rtc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (pps_tick),
    .ld_we   (stb.load),
    .wdata   (bus_wdata),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .load_q  (load_q)
  );

  sec_rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (pps_tick),
    .ld_we   (stb.load),
    .mt_we   (stb.match),
    .mk_we   (stb.mask),
    .clr_we  (stb.clear),
    .wdata   (bus_wdata),
    .cnt_nxt (cnt_nxt),
    .match_q (match_q),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .set_evt (set_evt),
    .irq     (alarm_irq)
  );

  sec_rtc_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .sel     (sel),
    .id_idx  (bus_addr[4:2]),
    .cnt_q   (cnt_q),
    .match_q (match_q),
    .load_q  (load_q),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .rdata   (bus_rdata)
  );

  // R5
  write_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb.load || stb.match) && cnt_nxt == (stb.match ? bus_wdata : match_q)) |=> raw_q);

  // R8
  ctrl_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> (bus_rdata == CNT_W'(1)));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !alarm_irq);

endmodule

// File: tb/sec_alarm_rtc_tb.sv
module sec_alarm_rtc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int unsigned checks = 0;
  int unsigned errs = 0;

  // Model state
  logic [31:0] m_cnt = '0, m_match = '0, m_load = '0;
  logic        m_mask = 1'b0, m_raw = 1'b0;

  always #5 clk = ~clk;

  sec_alarm_rtc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pps_tick  (tick),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .alarm_irq (irq)
  );

  // R9 ID bytes packed MSB first in the listed order
  function automatic logic [31:0] ref_id(input logic [11:0] a);
    logic [63:0] all;
    all = 64'h3110_1400_0DF0_05B1;
    return {24'h0, all[63 - 8*int'(a[4:2]) -: 8]};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a >= 12'hFE0 && a[1:0] == 2'b00) return ref_id(a);
    case (a)
      12'h000: return m_cnt;
      12'h004: return m_match;
      12'h008: return m_load;
      12'h00C: return 32'd1;
      12'h010: return {31'd0, m_mask};
      12'h014: return {31'd0, m_raw};
      12'h018: return {31'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [11:0] pick_addr(input int unsigned n);
    case (n % 12)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;
      3: return 12'h00C;  4: return 12'h010;  5: return 12'h014;
      6: return 12'h018;  7: return 12'h01C;
      8: return 12'hFE0 + 12'(4 * ($urandom % 8));
      9: return 12'h020;  10: return 12'h003;
      default: return 12'hFDC;
    endcase
  endfunction

  task automatic model(input logic t, input logic w, input logic [11:0] a, input logic [31:0] d);
    logic ld, mt, ev;
    logic [31:0] nc, nm;
    ld = w && a == 12'h008;
    mt = w && a == 12'h004;
    nc = ld ? d : (t ? m_cnt + 32'd1 : m_cnt);
    nm = mt ? d : m_match;
    ev = (t || ld || mt) && nc == nm;
    if (ld) m_load = d;
    if (w && a == 12'h010) m_mask = d[0];
    if (ev) m_raw = 1'b1;
    else if (w && a == 12'h01C && d[0]) m_raw = 1'b0;
    m_cnt = nc;
    m_match = nm;
  endtask

  task automatic step(input logic t, input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d;
    @(posedge clk);
    model(t, w, a, d);
  endtask

  task automatic chk_rd(input logic [11:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    tick = 1'b0; we = 1'b0; addr = a;
    #1;
    e = exp_rd(a);
    checks++;
    if (rdata !== e) begin
      errs++;
      $display("FAIL %s read 0x%03h: actual 0x%08h expected 0x%08h", req, a, rdata, e);
    end
  endtask

  task automatic chk_irq(input string req);
    logic e;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    #1;
    e = m_raw & m_mask;
    checks++;
    if (irq !== e) begin
      errs++;
      $display("FAIL %s irq: actual %0b expected %0b", req, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(12'h000, "R1"); chk_rd(12'h004, "R1"); chk_rd(12'h008, "R1");
    chk_rd(12'h010, "R1"); chk_rd(12'h014, "R1"); chk_irq("R1");

    // R2 counting, ignored write, wrap
    step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
    chk_rd(12'h000, "R2");
    step(0, 1, 12'h000, 32'h1234_5678);
    chk_rd(12'h000, "R2");
    step(0, 1, 12'h008, 32'hFFFF_FFFE);
    chk_rd(12'h008, "R3");
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    chk_rd(12'h000, "R2");

    // R3 load beats tick
    step(1, 1, 12'h008, 32'd500);
    chk_rd(12'h000, "R3");

    // R4 tick reaches match
    step(0, 1, 12'h008, 32'd10);
    step(0, 1, 12'h004, 32'd12);
    step(1, 0, 0, 0);
    chk_rd(12'h014, "R4");
    step(1, 0, 0, 0);
    chk_rd(12'h014, "R4");
    chk_rd(12'h004, "R4");

    // R6 mask
    chk_irq("R6"); chk_rd(12'h018, "R6");
    step(0, 1, 12'h010, 32'hFFFF_FFFF);
    chk_rd(12'h010, "R6"); chk_rd(12'h018, "R6"); chk_irq("R6");

    // R7 clear
    step(0, 1, 12'h01C, 32'hFFFF_FFFE);
    chk_rd(12'h014, "R7");
    step(0, 1, 12'h01C, 32'd1);
    chk_rd(12'h014, "R7"); chk_irq("R7"); chk_rd(12'h01C, "R7");

    // R5 immediate set from match write and from load write
    step(0, 1, 12'h004, 32'd12);
    chk_rd(12'h014, "R5"); chk_irq("R5");
    step(0, 1, 12'h01C, 32'd1);
    step(0, 1, 12'h008, 32'd12);
    chk_rd(12'h014, "R5");

    // R7 set event beats same-cycle clear
    step(0, 1, 12'h004, 32'd13);
    step(0, 1, 12'h01C, 32'd1);
    chk_rd(12'h014, "R7");
    step(1, 1, 12'h01C, 32'd1);
    chk_rd(12'h014, "R7"); chk_irq("R7");

    // R4 match below count fires after wrap
    step(0, 1, 12'h01C, 32'd1);
    step(0, 1, 12'h004, 32'd1);
    step(0, 1, 12'h008, 32'hFFFF_FFFF);
    step(1, 0, 0, 0);
    chk_rd(12'h014, "R4");
    step(1, 0, 0, 0);
    chk_rd(12'h014, "R4");

    // R8 control, read-only writes, unmapped
    step(0, 1, 12'h00C, 32'd0);
    chk_rd(12'h00C, "R8");
    step(0, 1, 12'h014, 32'd0);
    step(0, 1, 12'h018, 32'd0);
    chk_rd(12'h014, "R8"); chk_rd(12'h018, "R8");
    chk_rd(12'h020, "R8"); chk_rd(12'h003, "R8"); chk_rd(12'hFDC, "R8");

    // R9 ID block
    for (int i = 0; i < 8; i++) chk_rd(12'hFE0 + 12'(4 * i), "R9");

    // Random phase covering R2..R8
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom % 8;
      case (op)
        0, 1, 2: step(1, 0, 0, 0);
        3: step($urandom % 2, 1, 12'h008, m_match - ($urandom % 3));
        4: step($urandom % 2, 1, 12'h004, m_cnt + ($urandom % 3));
        5: step($urandom % 2, 1, 12'h010, $urandom);
        6: step($urandom % 2, 1, 12'h01C, $urandom);
        default: step($urandom % 2, 1, pick_addr($urandom), $urandom);
      endcase
      chk_rd(pick_addr($urandom), "R2-R9 random");
      chk_irq("R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule